// File: doc/BRIEF.md
# ASID-Qualified Multi-Way TLB

This block holds a small set of translation ways and answers address-translation requests for a processor core. Every entry stores a virtual page number, a physical page number, an 8-bit address-space identifier and a 4-bit attribute code. A ring-identifier register holds one identifier per privilege ring, so an entry is visible only while its identifier is loaded into one of the four ring slots. The ring slot that holds the identifier is the ring that owns the page.

For each request the block looks up all ways at once using the page index bits of the address. It then reports one of four things: the physical address, a multi-hit, a privilege violation, or an access-rights violation. The cache policy of the page comes with the physical address. On a miss the block computes the address of the page-table entry and asks a neighbour to fetch it through a request/acknowledge handshake. It installs the returned entry into a way picked by a round-robin counter and then answers the original request from that entry.

A maintenance port writes an entry, invalidates an entry, or probes the ways for an address. The ring-identifier register is written through its own strobe.

Top module: `asid_tlb`

## Requirements
- R1: After reset the ring-identifier register reads 0x04030201. A write stores bits 31:8 of the written value and forces bits 7:0 to 0x01. The result is visible on `rasid_q` in the cycle after the strobe.
- R2: An entry matches when its stored page number equals address bits 31:12 and its identifier is nonzero and equals one of the four bytes of the ring-identifier register. Byte n is ring n. When the identifier sits in several bytes, the lowest byte gives the ring. An entry whose identifier is in no byte never matches.
- R3: Cause codes are 0 ok, 1 instruction miss, 2 data miss, 3 instruction multi-hit, 4 data multi-hit, 5 instruction privilege, 6 data privilege, 7 fetch prohibited, 8 load prohibited, 9 store prohibited. Two or more matching ways give the multi-hit code of the access's variant. The check order is multi-hit, then miss, then privilege, then rights.
- R4: If the owning ring is numerically below the request's privilege level (`req_priv`), the result is the privilege cause.
- R5: Access kinds are 0 load, 1 store, 2 fetch; kind 3 acts as a load. Attribute codes below 12 grant read. Bit 0 of such a code adds execute and bit 1 adds write. Code 13 grants read and write. All other codes grant nothing. Fetch needs execute, store needs write, and load needs read. Cache codes are 0 bypass, 1 write-back, 2 write-through, 3 isolate. For codes below 12, bits 3:2 of 00, 01 and 10 select bypass, write-back and write-through. Code 13 selects isolate.
- R6: Each way has four entries, selected by address bits 13:12. A request that hits gets its response one cycle after it is accepted. The response gives the physical address as the stored page number joined with address bits 11:0, plus the owning ring.
- R7: On a miss, `refill_req` rises in the cycle after acceptance. `refill_addr` equals (`pt_base` OR address shifted right by 10) with bits 1:0 cleared. Both stay stable until `refill_ack`.
- R8: When `refill_ack` arrives with `refill_ok` high, the returned entry is installed into the way that is the next value of a 2-bit counter. That counter starts at 0, so the first refill goes to way 1, and it advances only on such refills. The entry's ring is entry bits 5:4, and its identifier is that ring's byte. The response, one cycle after the acknowledge, is judged from that ring and attribute. With `refill_ok` low the response is the miss cause and nothing is installed.
- R9: A write operation targets the way in address bits 1:0 and the entry in bits 13:12. It stores page number bits 31:12 of the address and, from the entry word, physical page bits 31:12 and attribute bits 3:0. The identifier is the ring byte selected by entry-word bits 5:4.
- R10: An invalidate operation clears the identifier of the entry selected by address bits 1:0 (way) and 13:12 (entry). All ways here are writable, so the identifier is always cleared.
- R11: A probe with a single match whose ring is at or above `op_priv` returns address bits 31:12 followed by twelve low bits that hold the way number ORed with 0x10 (`op_data` high) or 0x08 (low). A multi-hit returns 0 and raises `op_multi`. Any other case returns 0. The result appears with `op_done` one cycle after acceptance.
- R12: Operations are accepted only while no refill is pending. A pending operation blocks request acceptance in the same cycle (`req_ready` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rasid_we | input | 1 | Ring-identifier register write strobe |
| rasid_wdata | input | 32 | Ring-identifier write value |
| rasid_q | output | 32 | Current ring-identifier register |
| pt_base | input | 32 | Page-table base address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translation request accepted this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_priv | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Response valid pulse |
| rsp_cause | output | 4 | Result cause code |
| rsp_paddr | output | 32 | Physical address |
| rsp_ring | output | 2 | Ring owning the page |
| rsp_cache | output | 2 | Cache policy code |
| refill_req | output | 1 | Page-table entry fetch pending |
| refill_addr | output | 32 | Page-table entry address |
| refill_ack | input | 1 | Page-table entry returned |
| refill_ok | input | 1 | Fetch succeeded |
| refill_pte | input | 32 | Returned page-table entry |
| op_valid | input | 1 | Maintenance operation valid |
| op_ready | output | 1 | Operation accepted this cycle |
| op_code | input | 2 | 1 write, 2 invalidate, 3 probe |
| op_addr | input | 32 | Operation address (way in bits 1:0) |
| op_pte | input | 32 | Entry word for writes |
| op_priv | input | 2 | Privilege level for probes |
| op_data | input | 1 | Probe of data (1) or instruction (0) variant |
| op_done | output | 1 | Operation completed pulse |
| op_rdata | output | 32 | Probe result |
| op_multi | output | 1 | Probe found several matches |

## Verification
The lookup is driven against an empty array to force the refill path. It is then driven against a refilled page from every kind and privilege level, which separates the privilege check from the rights check and the read, write and execute grants from one another. A second write of the same page into another way creates a multi-hit, and invalidating one of the two copies shows that only the selected way lost its entry. The ring-identifier register is rewritten with bytes that repeat or fall to zero, so that rings come from the lowest byte and pages with no loaded identifier stop matching. Random sequences over a small pool of pages mix writes, invalidates, probes, refills with failed fetches, and all attribute codes, and they check the round-robin installation against a model.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned PAGE_BITS = 12;
  localparam int unsigned PN_W      = ADDR_W - PAGE_BITS;
  localparam int unsigned ID_W      = 8;
  localparam int unsigned RINGS     = 4;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [1:0] OPC_WRITE = 2'd1;
  localparam logic [1:0] OPC_INVAL = 2'd2;
  localparam logic [1:0] OPC_PROBE = 2'd3;

  typedef enum logic [3:0] {
    CAUSE_OK      = 4'd0,
    CAUSE_MISS_I  = 4'd1,
    CAUSE_MISS_D  = 4'd2,
    CAUSE_MULTI_I = 4'd3,
    CAUSE_MULTI_D = 4'd4,
    CAUSE_PRIV_I  = 4'd5,
    CAUSE_PRIV_D  = 4'd6,
    CAUSE_PROH_F  = 4'd7,
    CAUSE_PROH_L  = 4'd8,
    CAUSE_PROH_S  = 4'd9
  } cause_e;

  typedef enum logic [1:0] {
    CACHE_BYPASS  = 2'd0,
    CACHE_WB      = 2'd1,
    CACHE_WT      = 2'd2,
    CACHE_ISOLATE = 2'd3
  } cache_e;

  typedef struct packed {
    logic       ok;
    logic [1:0] ring;
  } ring_sel_t;

  // Lowest ring slot holding a nonzero identifier wins.
  function automatic ring_sel_t ring_of(input logic [ID_W-1:0] id,
                                        input logic [ADDR_W-1:0] ring_ids);
    ring_sel_t r;
    r.ok   = 1'b0;
    r.ring = 2'd0;
    for (int i = RINGS - 1; i >= 0; i--) begin
      if (id != '0 && ring_ids[ID_W*i +: ID_W] == id) begin
        r.ok   = 1'b1;
        r.ring = 2'(i);
      end
    end
    return r;
  endfunction

  function automatic logic [ID_W-1:0] id_of_ring(input logic [ADDR_W-1:0] ring_ids,
                                                 input logic [1:0] ring);
    return ring_ids[ID_W*ring +: ID_W];
  endfunction

endpackage

// File: rtl/asid_tlb_attr_dec.sv
module asid_tlb_attr_dec
  import asid_tlb_pkg::*;
(
  input  logic [3:0] attr,
  output logic       can_rd,
  output logic       can_wr,
  output logic       can_ex,
  output cache_e     cache
);

  logic normal;
  logic isolate;

  always_comb begin
    normal  = (attr < 4'd12);
    isolate = (attr == 4'd13);
    can_rd  = normal | isolate;
    can_wr  = (normal & attr[1]) | isolate;
    can_ex  = normal & attr[0];
    if (isolate) begin
      cache = CACHE_ISOLATE;
    end else if (normal && attr[3:2] == 2'b01) begin
      cache = CACHE_WB;
    end else if (normal && attr[3:2] == 2'b10) begin
      cache = CACHE_WT;
    end else begin
      cache = CACHE_BYPASS;
    end
  end

endmodule

// File: rtl/asid_tlb_way.sv
module asid_tlb_way #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned ID_W    = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [ID_W-1:0]  wr_id,
  input  logic [3:0]       wr_attr,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic             tag_hit,
  output logic [ID_W-1:0]  rd_id,
  output logic [PPN_W-1:0] rd_ppn,
  output logic [3:0]       rd_attr
);

  logic [VPN_W-1:0] vpn_q  [ENTRIES];
  logic [PPN_W-1:0] ppn_q  [ENTRIES];
  logic [3:0]       attr_q [ENTRIES];
  logic [ID_W-1:0]  id_q   [ENTRIES];
  logic [ID_W-1:0]  id_d   [ENTRIES];

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      id_d[e] = id_q[e];
      if (inv_en && inv_idx == IDX_W'(e)) id_d[e] = '0;
      if (wr_en && wr_idx == IDX_W'(e))   id_d[e] = wr_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) id_q[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) id_q[e] <= id_d[e];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx]  <= wr_vpn;
      ppn_q[wr_idx]  <= wr_ppn;
      attr_q[wr_idx] <= wr_attr;
    end
  end

  assign tag_hit = (vpn_q[rd_idx] == rd_vpn);
  assign rd_id   = id_q[rd_idx];
  assign rd_ppn  = ppn_q[rd_idx];
  assign rd_attr = attr_q[rd_idx];

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int unsigned NUM_WAYS    = 4,
  parameter int unsigned WAY_ENTRIES = 4,
  parameter logic [31:0] RING_ID_RST = 32'h0403_0201
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rasid_we,
  input  logic [31:0] rasid_wdata,
  output logic [31:0] rasid_q,
  input  logic [31:0] pt_base,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_kind,
  input  logic [1:0]  req_priv,
  output logic        rsp_valid,
  output logic [3:0]  rsp_cause,
  output logic [31:0] rsp_paddr,
  output logic [1:0]  rsp_ring,
  output logic [1:0]  rsp_cache,
  output logic        refill_req,
  output logic [31:0] refill_addr,
  input  logic        refill_ack,
  input  logic        refill_ok,
  input  logic [31:0] refill_pte,
  input  logic        op_valid,
  output logic        op_ready,
  input  logic [1:0]  op_code,
  input  logic [31:0] op_addr,
  input  logic [31:0] op_pte,
  input  logic [1:0]  op_priv,
  input  logic        op_data,
  output logic        op_done,
  output logic [31:0] op_rdata,
  output logic        op_multi
);

  localparam int unsigned IDX_W = $clog2(WAY_ENTRIES);
  localparam int unsigned WAY_W = $clog2(NUM_WAYS);
  localparam int unsigned PTE_SHIFT = 10;

  typedef enum logic {ST_IDLE = 1'b0, ST_WALK = 1'b1} state_e;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // State
  state_e             st_q, st_d;
  logic [31:0]        ring_ids_q, ring_ids_d;
  logic [WAY_W-1:0]   rr_q, rr_d;
  logic [31:0]        walk_va_q;
  logic [1:0]         walk_kind_q, walk_priv_q;
  logic [31:0]        pte_addr_q, pte_addr_d;
  logic               walk_en;
  logic               rsp_valid_q, rsp_valid_d;
  cause_e             rsp_cause_q, rsp_cause_d;
  logic [31:0]        rsp_paddr_q, rsp_paddr_d;
  logic [1:0]         rsp_ring_q, rsp_ring_d;
  cache_e             rsp_cache_q, rsp_cache_d;
  logic               op_done_q, op_done_d;
  logic [31:0]        op_rdata_q, op_rdata_d;
  logic               op_multi_q, op_multi_d;

  // Handshake qualifiers
  logic idle, op_fire, req_fire, refill_fire, refill_good;
  assign idle        = (st_q == ST_IDLE);
  assign op_fire     = op_valid & idle;
  assign req_fire    = req_valid & idle & ~op_valid;
  assign refill_fire = (st_q == ST_WALK) & refill_ack;
  assign refill_good = refill_fire & refill_ok;

  // Lookup port shared by requests and probes
  logic [31:0]      lk_va;
  logic [IDX_W-1:0] lk_idx;
  logic [PN_W-1:0]  lk_vpn;
  assign lk_va  = (op_fire && op_code == OPC_PROBE) ? op_addr : req_vaddr;
  assign lk_idx = lk_va[PAGE_BITS +: IDX_W];
  assign lk_vpn = lk_va[ADDR_W-1:PAGE_BITS];

  // Write port shared by the write operation and refill
  logic [WAY_W-1:0] rr_next;
  logic [31:0]      wr_va, wr_pte;
  logic [IDX_W-1:0] wr_idx;
  logic [ID_W-1:0]  wr_id;
  logic             op_wr, op_inv;
  assign rr_next = rr_q + 1'b1;
  assign wr_va   = idle ? op_addr : walk_va_q;
  assign wr_pte  = idle ? op_pte : refill_pte;
  assign wr_idx  = wr_va[PAGE_BITS +: IDX_W];
  assign wr_id   = id_of_ring(ring_ids_q, wr_pte[5:4]);
  assign op_wr   = op_fire & (op_code == OPC_WRITE);
  assign op_inv  = op_fire & (op_code == OPC_INVAL);

  logic [NUM_WAYS-1:0] match;
  logic [1:0]          way_ring [NUM_WAYS];
  logic [3:0]          way_attr [NUM_WAYS];
  logic [PN_W-1:0]     way_ppn  [NUM_WAYS];

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    logic            tag_hit, wr_en, inv_en;
    logic [ID_W-1:0] rd_id;
    ring_sel_t       rs;

    assign wr_en  = (op_wr && op_addr[WAY_W-1:0] == WAY_W'(g)) ||
                    (refill_good && rr_next == WAY_W'(g));
    assign inv_en = op_inv && op_addr[WAY_W-1:0] == WAY_W'(g);

    asid_tlb_way #(
      .ENTRIES (WAY_ENTRIES),
      .VPN_W   (PN_W),
      .PPN_W   (PN_W),
      .ID_W    (ID_W)
    ) u_way (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_vpn  (wr_va[ADDR_W-1:PAGE_BITS]),
      .wr_ppn  (wr_pte[ADDR_W-1:PAGE_BITS]),
      .wr_id   (wr_id),
      .wr_attr (wr_pte[3:0]),
      .inv_en  (inv_en),
      .inv_idx (op_addr[PAGE_BITS +: IDX_W]),
      .rd_idx  (lk_idx),
      .rd_vpn  (lk_vpn),
      .tag_hit (tag_hit),
      .rd_id   (rd_id),
      .rd_ppn  (way_ppn[g]),
      .rd_attr (way_attr[g])
    );

    assign rs          = ring_of(rd_id, ring_ids_q);
    assign match[g]    = tag_hit & rs.ok;
    assign way_ring[g] = rs.ring;
  end

  // Hit selection
  int unsigned      n_hits;
  logic [WAY_W-1:0] hit_way;
  logic [1:0]       hit_ring;
  logic [3:0]       hit_attr;
  logic [PN_W-1:0]  hit_ppn;
  always_comb begin
    n_hits   = $countones(match);
    hit_way  = '0;
    hit_ring = '0;
    hit_attr = '0;
    hit_ppn  = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (match[w]) begin
        hit_way  = WAY_W'(w);
        hit_ring = way_ring[w];
        hit_attr = way_attr[w];
        hit_ppn  = way_ppn[w];
      end
    end
  end

  // Privilege and rights evaluation (hit entry or returned entry)
  logic [1:0]      ev_ring, ev_kind, ev_priv;
  logic [3:0]      ev_attr;
  logic [PN_W-1:0] ev_ppn;
  logic [31:0]     ev_va;
  logic            dec_rd, dec_wr, dec_ex, ev_instr, ev_need;
  cache_e          dec_cache;
  cause_e          ev_cause;

  always_comb begin
    if (st_q == ST_WALK) begin
      ev_ring = refill_pte[5:4];
      ev_attr = refill_pte[3:0];
      ev_ppn  = refill_pte[ADDR_W-1:PAGE_BITS];
      ev_va   = walk_va_q;
      ev_kind = walk_kind_q;
      ev_priv = walk_priv_q;
    end else begin
      ev_ring = hit_ring;
      ev_attr = hit_attr;
      ev_ppn  = hit_ppn;
      ev_va   = req_vaddr;
      ev_kind = req_kind;
      ev_priv = req_priv;
    end
  end

  asid_tlb_attr_dec u_attr (
    .attr   (ev_attr),
    .can_rd (dec_rd),
    .can_wr (dec_wr),
    .can_ex (dec_ex),
    .cache  (dec_cache)
  );

  always_comb begin
    ev_instr = (ev_kind == KIND_FETCH);
    ev_need  = (ev_kind == KIND_STORE) ? dec_wr : (ev_instr ? dec_ex : dec_rd);
    if (ev_ring < ev_priv) begin
      ev_cause = ev_instr ? CAUSE_PRIV_I : CAUSE_PRIV_D;
    end else if (!ev_need) begin
      ev_cause = ev_instr ? CAUSE_PROH_F :
                 ((ev_kind == KIND_STORE) ? CAUSE_PROH_S : CAUSE_PROH_L);
    end else begin
      ev_cause = CAUSE_OK;
    end
  end

  // Next state
  always_comb begin
    st_d        = st_q;
    rr_d        = rr_q;
    ring_ids_d  = rasid_we ? {rasid_wdata[31:8], 8'h01} : ring_ids_q;
    walk_en     = 1'b0;
    pte_addr_d  = (pt_base | (req_vaddr >> PTE_SHIFT)) & ~32'h3;
    rsp_valid_d = 1'b0;
    rsp_cause_d = ev_cause;
    rsp_paddr_d = {ev_ppn, ev_va[PAGE_BITS-1:0]};
    rsp_ring_d  = ev_ring;
    rsp_cache_d = dec_cache;
    op_done_d   = 1'b0;
    op_rdata_d  = '0;
    op_multi_d  = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (op_fire) begin
          op_done_d = 1'b1;
          if (op_code == OPC_PROBE) begin
            if (n_hits > 1) begin
              op_multi_d = 1'b1;
            end else if (n_hits == 1 && hit_ring >= op_priv) begin
              op_rdata_d = {op_addr[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}} |
                           (op_data ? 32'h10 : 32'h08) | 32'(hit_way);
            end
          end
        end else if (req_fire) begin
          if (n_hits > 1) begin
            rsp_valid_d = 1'b1;
            rsp_cause_d = ev_instr ? CAUSE_MULTI_I : CAUSE_MULTI_D;
          end else if (n_hits == 0) begin
            st_d    = ST_WALK;
            walk_en = 1'b1;
          end else begin
            rsp_valid_d = 1'b1;
          end
        end
      end
      ST_WALK: begin
        if (refill_fire) begin
          st_d        = ST_IDLE;
          rsp_valid_d = 1'b1;
          if (refill_ok) begin
            rr_d = rr_next;
          end else begin
            rsp_cause_d = ev_instr ? CAUSE_MISS_I : CAUSE_MISS_D;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q        <= ST_IDLE;
      ring_ids_q  <= RING_ID_RST;
      rr_q        <= '0;
      rsp_valid_q <= 1'b0;
      op_done_q   <= 1'b0;
    end else begin
      st_q        <= st_d;
      ring_ids_q  <= ring_ids_d;
      rr_q        <= rr_d;
      rsp_valid_q <= rsp_valid_d;
      op_done_q   <= op_done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (walk_en) begin
      walk_va_q   <= req_vaddr;
      walk_kind_q <= req_kind;
      walk_priv_q <= req_priv;
      pte_addr_q  <= pte_addr_d;
    end
    if (rsp_valid_d) begin
      rsp_cause_q <= rsp_cause_d;
      rsp_paddr_q <= rsp_paddr_d;
      rsp_ring_q  <= rsp_ring_d;
      rsp_cache_q <= rsp_cache_d;
    end
    if (op_done_d) begin
      op_rdata_q <= op_rdata_d;
      op_multi_q <= op_multi_d;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{rasid_wdata[7:0], refill_pte[11:6], op_pte[11:6],
                         op_addr[PAGE_BITS-1:WAY_W]};

  assign rasid_q     = ring_ids_q;
  assign req_ready   = idle & ~op_valid;
  assign op_ready    = idle;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_cause   = rsp_cause_q;
  assign rsp_paddr   = rsp_paddr_q;
  assign rsp_ring    = rsp_ring_q;
  assign rsp_cache   = rsp_cache_q;
  assign refill_req  = (st_q == ST_WALK);
  assign refill_addr = pte_addr_q;
  assign op_done     = op_done_q;
  assign op_rdata    = op_rdata_q;
  assign op_multi    = op_multi_q;

endmodule

// File: rtl/asid_tlb_checker.sv
module asid_tlb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rasid_we,
  input logic [31:0] rasid_wdata,
  input logic [31:0] rasid_q,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_vaddr,
  input logic [1:0]  req_priv,
  input logic        rsp_valid,
  input logic [3:0]  rsp_cause,
  input logic [31:0] rsp_paddr,
  input logic [1:0]  rsp_ring,
  input logic        refill_req,
  input logic [31:0] refill_addr,
  input logic        refill_ack,
  input logic        op_valid,
  input logic        op_ready,
  input logic        op_done
);

  p_ring_id_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rasid_we |=> rasid_q == {$past(rasid_wdata[31:8]), 8'h01});

  p_hit_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_ready) && rsp_valid && rsp_cause == 4'd0)
      |-> rsp_paddr[11:0] == $past(req_vaddr[11:0]));

  p_ring_vs_priv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_ready) && rsp_valid && rsp_cause == 4'd0)
      |-> rsp_ring >= $past(req_priv));

  p_accept_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || refill_req));

  p_pte_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |-> refill_addr[1:0] == 2'b00);

  p_refill_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && !refill_ack) |=> (refill_req && $stable(refill_addr)));

  p_refill_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_req && refill_ack) |=> (rsp_valid && !refill_req));

  p_op_blocks_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid || refill_req) |-> !req_ready);

  p_op_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> op_done);

endmodule

bind asid_tlb asid_tlb_checker u_asid_tlb_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .rasid_we    (rasid_we),
  .rasid_wdata (rasid_wdata),
  .rasid_q     (rasid_q),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_vaddr   (req_vaddr),
  .req_priv    (req_priv),
  .rsp_valid   (rsp_valid),
  .rsp_cause   (rsp_cause),
  .rsp_paddr   (rsp_paddr),
  .rsp_ring    (rsp_ring),
  .refill_req  (refill_req),
  .refill_addr (refill_addr),
  .refill_ack  (refill_ack),
  .op_valid    (op_valid),
  .op_ready    (op_ready),
  .op_done     (op_done)
);

// File: tb/asid_tlb_bench.sv
`timescale 1ns/1ps
module asid_tlb_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rasid_we;
  logic [31:0] rasid_wdata;
  logic [31:0] rasid_q;
  logic [31:0] pt_base;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic [1:0]  req_priv;
  logic        rsp_valid;
  logic [3:0]  rsp_cause;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_ring;
  logic [1:0]  rsp_cache;
  logic        refill_req;
  logic [31:0] refill_addr;
  logic        refill_ack;
  logic        refill_ok;
  logic [31:0] refill_pte;
  logic        op_valid;
  logic        op_ready;
  logic [1:0]  op_code;
  logic [31:0] op_addr;
  logic [31:0] op_pte;
  logic [1:0]  op_priv;
  logic        op_data;
  logic        op_done;
  logic [31:0] op_rdata;
  logic        op_multi;

  always #4 clk = ~clk;

  asid_tlb u_asid_tlb (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference model
  logic [19:0] m_vpn  [4][4];
  logic [19:0] m_ppn  [4][4];
  logic [3:0]  m_attr [4][4];
  logic [7:0]  m_id   [4][4];
  logic [31:0] m_rid;
  int          m_rr;

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic int ring_for(input logic [7:0] id);
    if (id == 8'h00) return 4;
    for (int i = 0; i < 4; i++) if (m_rid[8*i +: 8] == id) return i;
    return 4;
  endfunction

  function automatic void m_hits(input logic [31:0] va, output int nh, output int hw);
    int ix;
    ix = int'(va[13:12]);
    nh = 0;
    hw = 0;
    for (int w = 0; w < 4; w++) begin
      if (m_vpn[w][ix] == va[31:12] && ring_for(m_id[w][ix]) < 4) begin
        nh++;
        hw = w;
      end
    end
  endfunction

  function automatic void m_eval(input logic [31:0] va, input logic [1:0] kind,
                                 input logic [1:0] priv, input int ring,
                                 input logic [3:0] attr, input logic [19:0] ppn,
                                 output logic [3:0] cause, output logic [31:0] pa,
                                 output logic [1:0] cache);
    logic r, w, x, need;
    r = (attr < 12) || (attr == 13);
    w = ((attr < 12) && attr[1]) || (attr == 13);
    x = (attr < 12) && attr[0];
    if (attr == 13) cache = 2'd3;
    else if (attr < 12) cache = (attr[3:2] == 2'b01) ? 2'd1 : (attr[3:2] == 2'b10) ? 2'd2 : 2'd0;
    else cache = 2'd0;
    need = (kind == 2'd1) ? w : (kind == 2'd2) ? x : r;
    if (ring < int'(priv)) cause = (kind == 2'd2) ? 4'd5 : 4'd6;
    else if (!need) cause = (kind == 2'd2) ? 4'd7 : (kind == 2'd1) ? 4'd9 : 4'd8;
    else cause = 4'd0;
    pa = {ppn, va[11:0]};
  endfunction

  task automatic do_req(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] priv,
                        input logic [31:0] pte, input bit ok, input string rq);
    int nh, hw, ix, ring;
    logic [3:0] ec;
    logic [31:0] ep;
    logic [1:0] ecache;
    ix = int'(va[13:12]);
    m_hits(va, nh, hw);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_priv = priv;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ring = 0;
    if (nh == 0) begin
      chk("R7", "refill_req", {31'd0, refill_req}, 32'd1);
      chk("R7", "refill_addr", refill_addr, (pt_base | (va >> 10)) & ~32'h3);
      repeat ($urandom % 3) @(negedge clk);
      refill_ack = 1'b1; refill_ok = ok; refill_pte = pte;
      @(posedge clk);
      @(negedge clk);
      refill_ack = 1'b0;
      if (ok) begin
        m_rr = (m_rr + 1) % 4;
        m_vpn[m_rr][ix]  = va[31:12];
        m_ppn[m_rr][ix]  = pte[31:12];
        m_attr[m_rr][ix] = pte[3:0];
        m_id[m_rr][ix]   = m_rid[8*pte[5:4] +: 8];
        ring = int'(pte[5:4]);
        m_eval(va, kind, priv, ring, pte[3:0], pte[31:12], ec, ep, ecache);
      end else begin
        ec = (kind == 2'd2) ? 4'd1 : 4'd2;
        ep = '0; ecache = '0;
      end
    end else if (nh > 1) begin
      ec = (kind == 2'd2) ? 4'd3 : 4'd4;
      ep = '0; ecache = '0;
    end else begin
      ring = ring_for(m_id[hw][ix]);
      m_eval(va, kind, priv, ring, m_attr[hw][ix], m_ppn[hw][ix], ec, ep, ecache);
    end
    chk(rq, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(rq, "rsp_cause", {28'd0, rsp_cause}, {28'd0, ec});
    if (ec == 4'd0) begin
      chk("R6", "rsp_paddr", rsp_paddr, ep);
      chk("R5", "rsp_cache", {30'd0, rsp_cache}, {30'd0, ecache});
      chk("R2", "rsp_ring", {30'd0, rsp_ring}, 32'(ring));
    end
  endtask

  task automatic do_op(input logic [1:0] code, input logic [31:0] addr, input logic [31:0] pte,
                       input logic [1:0] priv, input bit dflag, input string rq);
    int nh, hw, ix, w;
    logic [31:0] exp_rd;
    logic exp_multi;
    ix = int'(addr[13:12]);
    w  = int'(addr[1:0]);
    m_hits(addr, nh, hw);
    exp_multi = (nh > 1);
    exp_rd = '0;
    if (nh == 1 && ring_for(m_id[hw][ix]) >= int'(priv))
      exp_rd = {addr[31:12], 12'h000} | (dflag ? 32'h10 : 32'h08) | 32'(hw);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_addr = addr; op_pte = pte;
    op_priv = priv; op_data = dflag;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk(rq, "op_done", {31'd0, op_done}, 32'd1);
    if (code == 2'd3) begin
      chk("R11", "op_rdata", op_rdata, exp_rd);
      chk("R11", "op_multi", {31'd0, op_multi}, {31'd0, exp_multi});
    end else if (code == 2'd1) begin
      m_vpn[w][ix]  = addr[31:12];
      m_ppn[w][ix]  = pte[31:12];
      m_attr[w][ix] = pte[3:0];
      m_id[w][ix]   = m_rid[8*pte[5:4] +: 8];
    end else if (code == 2'd2) begin
      m_id[w][ix] = 8'h00;
    end
  endtask

  task automatic do_rid(input logic [31:0] v);
    @(negedge clk);
    rasid_we = 1'b1; rasid_wdata = v;
    @(posedge clk);
    @(negedge clk);
    rasid_we = 1'b0;
    m_rid = {v[31:8], 8'h01};
    chk("R1", "rasid_q", rasid_q, m_rid);
  endtask

  function automatic logic [31:0] rnd_va();
    logic [19:0] pool [6];
    pool[0] = 20'h00012; pool[1] = 20'h00013; pool[2] = 20'h80001;
    pool[3] = 20'h80002; pool[4] = 20'hFFFF0; pool[5] = 20'h00103;
    return {pool[$urandom % 6], 12'($urandom)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    rasid_we = 0; rasid_wdata = 0; pt_base = 32'h4000_0000;
    req_valid = 0; req_vaddr = 0; req_kind = 0; req_priv = 0;
    refill_ack = 0; refill_ok = 0; refill_pte = 0;
    op_valid = 0; op_code = 0; op_addr = 0; op_pte = 0; op_priv = 0; op_data = 0;
    m_rid = 32'h0403_0201; m_rr = 0;
    for (int w = 0; w < 4; w++)
      for (int e = 0; e < 4; e++) begin
        m_vpn[w][e] = '0; m_ppn[w][e] = '0; m_attr[w][e] = '0; m_id[w][e] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk("R1", "rasid_q reset", rasid_q, 32'h0403_0201);
    chk("R12", "req_ready reset", {31'd0, req_ready}, 32'd1);
    chk("R6", "rsp_valid reset", {31'd0, rsp_valid}, 32'd0);
    chk("R7", "refill_req reset", {31'd0, refill_req}, 32'd0);

    // Empty array: miss and refill into way 1, ring 1, attr 6 (rw, write-back)
    do_req(32'h0001_2345, 2'd0, 2'd0, 32'hABCD_E016, 1'b1, "R8");
    do_req(32'h0001_2ABC, 2'd0, 2'd1, 32'h0, 1'b1, "R6");
    do_op(2'd3, 32'h0001_2000, 32'h0, 2'd0, 1'b1, "R11");
    do_op(2'd3, 32'h0001_2000, 32'h0, 2'd2, 1'b0, "R11");
    do_req(32'h0001_2004, 2'd1, 2'd2, 32'h0, 1'b1, "R4");
    do_req(32'h0001_2008, 2'd2, 2'd0, 32'h0, 1'b1, "R5");
    // Duplicate page in way 2 -> multi-hit
    do_op(2'd1, 32'h0001_2002, 32'h1234_5005, 2'd0, 1'b0, "R9");
    do_req(32'h0001_2010, 2'd0, 2'd0, 32'h0, 1'b1, "R3");
    do_req(32'h0001_2010, 2'd2, 2'd0, 32'h0, 1'b1, "R3");
    do_op(2'd3, 32'h0001_2000, 32'h0, 2'd0, 1'b1, "R11");
    // Invalidate way 1 copy: way 2 remains (attr 5, ring 0, fetch ok)
    do_op(2'd2, 32'h0001_2001, 32'h0, 2'd0, 1'b0, "R10");
    do_req(32'h0001_2020, 2'd2, 2'd0, 32'h0, 1'b1, "R10");
    do_op(2'd2, 32'h0001_2002, 32'h0, 2'd0, 1'b0, "R10");
    do_op(2'd3, 32'h0001_2000, 32'h0, 2'd0, 1'b1, "R10");
    // Failed fetch of the entry -> instruction miss, counter holds
    do_req(32'h0001_2030, 2'd2, 2'd0, 32'h0, 1'b0, "R8");
    // Isolate attribute, ring 3
    do_req(32'h8000_1444, 2'd1, 2'd3, 32'h0000_703D, 1'b1, "R5");
    // Ring identifier rewrite: byte 3 duplicates byte 2, byte 1 becomes zero
    do_rid(32'hCCCC_00FF);
    do_op(2'd1, 32'h8000_2003, 32'h0005_5026, 2'd0, 1'b0, "R9");
    do_req(32'h8000_2100, 2'd0, 2'd2, 32'h0, 1'b1, "R2");
    do_req(32'h8000_1000, 2'd0, 2'd0, 32'h0000_8010, 1'b1, "R2");

    // Pending operation blocks requests
    @(negedge clk);
    op_valid = 1'b1; op_code = 2'd3; op_addr = 32'h0; op_priv = 0; op_data = 0;
    req_valid = 1'b1; req_vaddr = 32'h0001_2000; req_kind = 0; req_priv = 0;
    #1;
    chk("R12", "req_ready with op", {31'd0, req_ready}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; req_valid = 1'b0;
    chk("R12", "rsp_valid after blocked req", {31'd0, rsp_valid}, 32'd0);
    chk("R12", "op_done", {31'd0, op_done}, 32'd1);

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int sel;
      sel = $urandom % 10;
      if (sel < 5) begin
        do_req(rnd_va(), 2'($urandom % 3), 2'($urandom), $urandom, ($urandom % 5) != 0, "R6");
      end else if (sel < 7) begin
        do_op(2'd1, rnd_va(), $urandom, 2'd0, 1'b0, "R9");
      end else if (sel < 8) begin
        do_op(2'd2, rnd_va(), 32'h0, 2'd0, 1'b0, "R10");
      end else if (sel < 9) begin
        do_op(2'd3, rnd_va(), 32'h0, 2'($urandom), 1'($urandom), "R11");
      end else begin
        logic [31:0] v;
        v = $urandom;
        if ($urandom % 2) v[31:24] = v[15:8];
        do_rid(v);
      end
    end

    finished = 1;
    report();
  end

endmodule